// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block derives the bit clock and the frame (left/right) clock of a codec serial audio port from the external master clock, and drives a gated copy of that master clock to a pin. All timing comes from a single frame counter clocked by the master clock. So the bit clock and frame clock are always phase-locked to it and to each other. Configuration inputs select how many master clock cycles make up one sample frame (256, 512 or 1024), whether a frame holds 64 or 32 bit clock periods, whether the block is the clock master, and whether the master clock pin is enabled.

Two power bits, one for the converter input path and one for the output path, govern the block. While both are 0 it rests in state `ST_OFF`: the counter is held at zero, the clock outputs are low, and the shadow configuration registers reload from the inputs. Transition `WAKE` (either power bit 1) moves it to `ST_RUN`, where the counter sweeps one frame after another. Transition `SLEEP` (both power bits 0) returns it to `ST_OFF`. The frame ratio is only taken while the block is in `ST_OFF`. The frame format is taken then and at every frame boundary.

In slave mode the block leaves the bit and frame clock pins to the outside: their enables are low and their data values are held low. Only the master clock output stays under control.

Top module: `audio_sclk_gen`

## Requirements
- R1: The ratio select code sets the frame length N in master clock cycles: 00 gives 256, 01 gives 512, 10 gives 1024, and 11 gives 256. After reset the active ratio is 256.
- R2: With the format bit at 0, a frame holds 64 bit clock periods of N/64 master cycles each. With the format bit at 1, it holds 32 periods of N/32 cycles each.
- R3: With the master clock enable at 0, `mclk_o` is low. With it at 1, `mclk_o` follows `mclk_i`. A change of the enable takes effect at the next falling edge of `mclk_i`.
- R4: In master mode, once a clock edge has seen both power bits at 0, `bclk_o` and `lrclk_o` are low from the next cycle on. They stay low until the block wakes again.
- R5: In slave mode (`master_i` = 0), `bclk_oe_o` and `lrclk_oe_o` are 0 and `bclk_o` and `lrclk_o` are 0, in every state.
- R6: A change of the ratio select while either power bit is 1 has no effect on the frame length. The new code applies only after a clock edge with both power bits at 0.
- R7: `lrclk_o` is low for the first N/2 cycles of each frame (left) and high for the last N/2 (right). It changes only in the same cycle as a falling edge of `bclk_o`.
- R8: After the clock edge that wakes the block, the frame counter starts at zero. `bclk_o` first rises N/(2B) cycles later, where B is the number of bit clock periods per frame. `lrclk_o` first rises N/2 cycles later, an exact number of bit clock periods.
- R9: While running, successive rising edges of `lrclk_o` are exactly N master cycles apart, with exactly B rising edges of `bclk_o` between them.
- R10: A change of the format bit while running takes effect at the next frame boundary, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock; the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel_i | input | 2 | Frame length select (master cycles per sample) |
| bit_fmt_i | input | 1 | 0: 64 bit clocks per frame, 1: 32 |
| mclk_out_en_i | input | 1 | Enables the master clock output pin |
| master_i | input | 1 | 1: block drives bit and frame clocks; 0: slave |
| pwr_adc_i | input | 1 | Input converter path power bit |
| pwr_dac_i | input | 1 | Output converter path power bit |
| mclk_o | output | 1 | Gated copy of the master clock |
| bclk_o | output | 1 | Bit clock value |
| bclk_oe_o | output | 1 | Drive enable for the bit clock pin |
| lrclk_o | output | 1 | Frame clock value (low = left) |
| lrclk_oe_o | output | 1 | Drive enable for the frame clock pin |

## Verification
A wrong frame counter or wrong shadow ratio shows up as a frame clock edge that arrives early or late. That is visible at `lrclk_o` within one frame, at most 1024 master cycles. A wrong format shadow changes the bit clock period within one bit period, and it is caught by counting bit clock edges per frame. A wrong state (running while powered down, or failing to restart from zero) shows at `bclk_o` in the first cycle after the power edge or at the first bit clock edge after waking. The bench checks both cases against cycle counts taken from the requirements.

// File: rtl/asg_pkg.sv
package asg_pkg;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } asg_state_t;

    // Extra frame-length exponent selected by the two-bit ratio code.
    // Codes 0 and 3 share the base ratio.
    function automatic logic [1:0] ratio_shift(input logic [1:0] code);
        logic [1:0] sh;
        unique case (code)
            2'd1:    sh = 2'd1;
            2'd2:    sh = 2'd2;
            default: sh = 2'd0;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/asg_ctrl.sv
module asg_ctrl
    import asg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_any,
    output asg_state_t state,
    output logic       run,
    output logic       cfg_load
);

    asg_state_t state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // next state: WAKE and SLEEP transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: if (pwr_any)  state_nx = ST_RUN;   // WAKE
            ST_RUN: if (!pwr_any) state_nx = ST_OFF;   // SLEEP
            default:              state_nx = ST_OFF;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        run      = 1'b0;
        cfg_load = 1'b0;
        unique case (state)
            ST_OFF: cfg_load = 1'b1;
            ST_RUN: run      = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/asg_cfg.sv
module asg_cfg
    import asg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_load,
    input  logic       frame_end,
    input  logic [1:0] ratio_sel,
    input  logic       bit_fmt,
    output logic [1:0] ratio_sh,
    output logic       fmt_act
);

    // ratio shadow: only refreshed while the block is off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_sh <= 2'd0;
        end else if (cfg_load) begin
            ratio_sh <= ratio_shift(ratio_sel);
        end
    end

    // format shadow: refreshed while off and at every frame boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_act <= 1'b0;
        end else if (cfg_load || frame_end) begin
            fmt_act <= bit_fmt;
        end
    end

endmodule

// File: rtl/asg_div.sv
module asg_div #(
    parameter int BASE_LOG2 = 8,
    parameter int WIDE_LOG2 = 6,
    localparam int CNT_W    = BASE_LOG2 + 2,
    localparam int IDX_W    = $clog2(CNT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       ratio_sh,
    input  logic             fmt_act,
    output logic [CNT_W-1:0] cnt,
    output logic             frame_end,
    output logic             bclk_raw,
    output logic             lrclk_raw
);

    logic [IDX_W-1:0] frame_log2;
    logic [IDX_W-1:0] bit_log2;
    logic [CNT_W-1:0] frame_last;

    always_comb begin
        frame_log2 = IDX_W'(BASE_LOG2) + IDX_W'(ratio_sh);
        bit_log2   = frame_log2 - (fmt_act ? IDX_W'(WIDE_LOG2 - 1) : IDX_W'(WIDE_LOG2));
        frame_last = CNT_W'((1 << frame_log2) - 1);
    end

    assign frame_end = run && (cnt == frame_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || frame_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // bit clock: top bit of the per-bit sub-count; frame clock: top bit of the frame count
    assign bclk_raw  = cnt[bit_log2 - 1'b1];
    assign lrclk_raw = cnt[frame_log2 - 1'b1];

endmodule

// File: rtl/asg_mclk_gate.sv
module asg_mclk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic gclk
);

    logic en_lo;

    // enable captured while the clock is low, so the gated output never glitches
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_lo <= 1'b0;
        end else begin
            en_lo <= enable;
        end
    end

    assign gclk = clk & en_lo;

endmodule

// File: rtl/audio_sclk_gen.sv
module audio_sclk_gen
    import asg_pkg::*;
#(
    parameter int BASE_LOG2 = 8,
    parameter int WIDE_LOG2 = 6,
    localparam int CNT_W    = BASE_LOG2 + 2
) (
    input  logic       mclk_i,
    input  logic       rst_n,
    input  logic [1:0] ratio_sel_i,
    input  logic       bit_fmt_i,
    input  logic       mclk_out_en_i,
    input  logic       master_i,
    input  logic       pwr_adc_i,
    input  logic       pwr_dac_i,
    output logic       mclk_o,
    output logic       bclk_o,
    output logic       bclk_oe_o,
    output logic       lrclk_o,
    output logic       lrclk_oe_o
);

    asg_state_t       state;
    logic             run;
    logic             cfg_load;
    logic             frame_end;
    logic [1:0]       ratio_sh;
    logic             fmt_act;
    logic [CNT_W-1:0] cnt;
    logic             bclk_raw;
    logic             lrclk_raw;

    asg_ctrl u_ctrl (
        .clk      (mclk_i),
        .rst_n    (rst_n),
        .pwr_any  (pwr_adc_i | pwr_dac_i),
        .state    (state),
        .run      (run),
        .cfg_load (cfg_load)
    );

    asg_cfg u_cfg (
        .clk       (mclk_i),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .frame_end (frame_end),
        .ratio_sel (ratio_sel_i),
        .bit_fmt   (bit_fmt_i),
        .ratio_sh  (ratio_sh),
        .fmt_act   (fmt_act)
    );

    asg_div #(
        .BASE_LOG2 (BASE_LOG2),
        .WIDE_LOG2 (WIDE_LOG2)
    ) u_div (
        .clk       (mclk_i),
        .rst_n     (rst_n),
        .run       (run),
        .ratio_sh  (ratio_sh),
        .fmt_act   (fmt_act),
        .cnt       (cnt),
        .frame_end (frame_end),
        .bclk_raw  (bclk_raw),
        .lrclk_raw (lrclk_raw)
    );

    asg_mclk_gate u_gate (
        .clk    (mclk_i),
        .rst_n  (rst_n),
        .enable (mclk_out_en_i),
        .gclk   (mclk_o)
    );

    assign bclk_oe_o  = master_i;
    assign lrclk_oe_o = master_i;
    assign bclk_o     = master_i & run & bclk_raw;
    assign lrclk_o    = master_i & run & lrclk_raw;

endmodule

// File: rtl/asg_chk.sv
module asg_chk
    import asg_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input logic             mclk_i,
    input logic             rst_n,
    input logic             master_i,
    input logic             pwr_adc_i,
    input logic             pwr_dac_i,
    input logic             bclk_o,
    input logic             lrclk_o,
    input asg_state_t       state,
    input logic [CNT_W-1:0] cnt,
    input logic [1:0]       ratio_sh,
    input logic             fmt_act
);

    logic pwr_any;
    assign pwr_any = pwr_adc_i | pwr_dac_i;

    // R4
    a_r4_pd_low: assert property (@(posedge mclk_i) disable iff (!rst_n)
        (!pwr_any) |=> (!bclk_o && !lrclk_o));

    // R6
    a_r6_ratio_hold: assert property (@(posedge mclk_i) disable iff (!rst_n)
        (state == ST_RUN && $past(state == ST_RUN)) |-> $stable(ratio_sh));

    // R7
    a_r7_lr_on_bfall: assert property (@(posedge mclk_i) disable iff (!rst_n)
        (master_i && $past(master_i) && $past(pwr_any) && !$stable(lrclk_o))
        |-> $fell(bclk_o));

    // R8
    a_r8_restart_zero: assert property (@(posedge mclk_i) disable iff (!rst_n)
        $rose(state == ST_RUN) |-> (cnt == '0));

    // R10
    a_r10_fmt_boundary: assert property (@(posedge mclk_i) disable iff (!rst_n)
        (state == ST_RUN && $past(state == ST_RUN) && !$stable(fmt_act)) |-> (cnt == '0));

endmodule

bind audio_sclk_gen asg_chk #(.CNT_W(CNT_W)) u_chk (
    .mclk_i    (mclk_i),
    .rst_n     (rst_n),
    .master_i  (master_i),
    .pwr_adc_i (pwr_adc_i),
    .pwr_dac_i (pwr_dac_i),
    .bclk_o    (bclk_o),
    .lrclk_o   (lrclk_o),
    .state     (state),
    .cnt       (cnt),
    .ratio_sh  (ratio_sh),
    .fmt_act   (fmt_act)
);

// File: tb/audio_sclk_gen_tb.sv
`timescale 1ns/1ps
module audio_sclk_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ratio_sel = 2'd0;
    logic       bit_fmt = 1'b0;
    logic       mclk_en = 1'b0;
    logic       master = 1'b1;
    logic       pwr_adc = 1'b0;
    logic       pwr_dac = 1'b0;
    logic       mclk_o, bclk_o, bclk_oe, lrclk_o, lrclk_oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    audio_sclk_gen u_dut (
        .mclk_i        (clk),
        .rst_n         (rst_n),
        .ratio_sel_i   (ratio_sel),
        .bit_fmt_i     (bit_fmt),
        .mclk_out_en_i (mclk_en),
        .master_i      (master),
        .pwr_adc_i     (pwr_adc),
        .pwr_dac_i     (pwr_dac),
        .mclk_o        (mclk_o),
        .bclk_o        (bclk_o),
        .bclk_oe_o     (bclk_oe),
        .lrclk_o       (lrclk_o),
        .lrclk_oe_o    (lrclk_oe)
    );

    // Expected behaviour built from the requirements
    int m_on, m_cnt, m_sh, m_fmt;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_on <= 0; m_cnt <= 0; m_sh <= 0; m_fmt <= 0;
        end else if (m_on == 0) begin
            m_cnt <= 0;
            m_sh  <= (ratio_sel == 2'd3) ? 0 : int'(ratio_sel);
            m_fmt <= int'(bit_fmt);
            m_on  <= int'(pwr_adc | pwr_dac);
        end else if (!(pwr_adc | pwr_dac)) begin
            m_on <= 0; m_cnt <= 0;
        end else if (m_cnt == (256 << m_sh) - 1) begin
            m_cnt <= 0; m_fmt <= int'(bit_fmt);
        end else begin
            m_cnt <= m_cnt + 1;
        end
    end

    function automatic logic exp_b();
        int k = 8 + m_sh - (m_fmt != 0 ? 5 : 6);
        return master && (m_on != 0) && (((m_cnt >> (k - 1)) & 1) != 0);
    endfunction
    function automatic logic exp_l();
        return master && (m_on != 0) && (((m_cnt >> (7 + m_sh)) & 1) != 0);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive_step();
        @(posedge clk); #1;
    endtask

    task automatic power(input logic on);
        drive_step();
        pwr_adc = on; pwr_dac = 1'b0;
    endtask

    // compare outputs against the expectation for n cycles; one check
    task automatic compare_window(input string tag, input int n);
        int bad = 0; int fa = 0; int fe = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bclk_o !== exp_b() || lrclk_o !== exp_l() ||
                bclk_oe !== master || lrclk_oe !== master) begin
                if (bad == 0) begin
                    fa = {bclk_oe, lrclk_oe, bclk_o, lrclk_o};
                    fe = {master, master, exp_b(), exp_l()};
                end
                bad++;
            end
        end
        check(tag, fa, fe);
    endtask

    // measure one frame between rising edges of lrclk_o
    task automatic measure_frame(output int len, output int rises, output int highs);
        logic pl, pb;
        int guard = 0;
        len = 0; rises = 0; highs = 0;
        @(negedge clk); pl = lrclk_o;
        while (!(pl == 1'b0 && lrclk_o == 1'b1) && guard < 3000) begin
            pl = lrclk_o; @(negedge clk); guard++;
        end
        pl = lrclk_o; pb = bclk_o;
        do begin
            len++;
            if (lrclk_o) highs++;
            @(negedge clk);
            if (!pb && bclk_o) rises++;
            pb = bclk_o;
            guard++;
        end while (!(pl == 1'b0 && lrclk_o == 1'b1) && guard < 3000 && ((pl = lrclk_o) || 1'b1));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R4 reset bclk low", bclk_o, 0);
        check("R4 reset lrclk low", lrclk_o, 0);
        check("R3 reset mclk_o low", mclk_o, 0);
    endtask

    task automatic t_ratio(input logic [1:0] code, input logic fmt);
        int n = 256 << ((code == 2'd3) ? 0 : int'(code));
        int b = fmt ? 32 : 64;
        int len, rises, highs;
        power(1'b0);
        drive_step(); ratio_sel = code; bit_fmt = fmt;
        drive_step();
        power(1'b1);
        compare_window($sformatf("R1 R2 code %0d fmt %0d waveform", code, fmt), n + 8);
        measure_frame(len, rises, highs);
        check($sformatf("R1 R9 frame length code %0d", code), len, n);
        check($sformatf("R2 R9 bit clocks per frame fmt %0d", fmt), rises, b);
        check("R7 right half length", highs, n / 2);
    endtask

    task automatic t_mclk();
        drive_step(); mclk_en = 1'b0;
        repeat (2) @(posedge clk);
        #1 check("R3 disabled high phase", mclk_o, 0);
        drive_step(); mclk_en = 1'b1;
        repeat (2) @(posedge clk);
        #1 check("R3 enabled high phase", mclk_o, 1);
        @(negedge clk); #1 check("R3 enabled low phase", mclk_o, 0);
    endtask

    task automatic t_slave();
        int hi = 0;
        power(1'b1);
        drive_step(); master = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            hi += bclk_o + lrclk_o + bclk_oe + lrclk_oe;
        end
        check("R5 slave no drive", hi, 0);
        #1 check("R5 R3 slave mclk_o follows low", mclk_o, 0);
        drive_step(); master = 1'b1;
    endtask

    task automatic t_ratio_ignored();
        int len, rises, highs;
        power(1'b0);
        drive_step(); ratio_sel = 2'd0; bit_fmt = 1'b0;
        power(1'b1);
        repeat (10) @(posedge clk);
        #1 ratio_sel = 2'd2;
        measure_frame(len, rises, highs);
        check("R6 ratio change while running ignored", len, 256);
        power(1'b0);
        drive_step();
        power(1'b1);
        measure_frame(len, rises, highs);
        check("R6 ratio applied after power down", len, 1024);
    endtask

    task automatic t_fmt_switch();
        int len, rises, highs;
        power(1'b0);
        drive_step(); ratio_sel = 2'd1; bit_fmt = 1'b0;
        power(1'b1);
        repeat (100) @(posedge clk);
        #1 bit_fmt = 1'b1;
        compare_window("R10 format switch at frame boundary", 1000);
        measure_frame(len, rises, highs);
        check("R10 new format after boundary", rises, 32);
    endtask

    task automatic t_powerup(input logic [1:0] code, input logic fmt);
        int n = 256 << int'(code);
        int b = fmt ? 32 : 64;
        int first_b = -1; int first_l = -1;
        power(1'b0);
        drive_step(); ratio_sel = code; bit_fmt = fmt;
        drive_step();
        pwr_dac = 1'b1;        // wake through the other power bit
        @(posedge clk);        // waking edge
        for (int j = 0; j <= n / 2; j++) begin
            @(negedge clk);
            if (first_b < 0 && bclk_o) first_b = j;
            if (first_l < 0 && lrclk_o) first_l = j;
        end
        check("R8 first bit clock rise", first_b, n / (2 * b));
        check("R8 first frame clock rise", first_l, n / 2);
        drive_step(); pwr_dac = 1'b0;
    endtask

    task automatic t_powerdown();
        int hi = 0;
        power(1'b1);
        repeat (300) @(posedge clk);
        #1 pwr_adc = 1'b0; pwr_dac = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            hi += bclk_o + lrclk_o;
        end
        check("R4 outputs low after power down", hi, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_mclk();
        t_ratio(2'd0, 1'b0);
        t_ratio(2'd1, 1'b1);
        t_ratio(2'd2, 1'b0);
        t_ratio(2'd3, 1'b1);
        t_slave();
        t_ratio_ignored();
        t_fmt_switch();
        t_powerup(2'd0, 1'b0);
        t_powerup(2'd2, 1'b1);
        t_powerdown();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule